// File: doc/BRIEF.md
# Line-Tagged Shared Receive Queue

This block collects received characters from four serial lines into one circular queue. Every stored entry keeps the 8-bit character together with the 2-bit number of the line it came in on. A single host read port removes the oldest entry and returns it as a packed 16-bit receive word. The queue also drives a data-available flag for the surrounding status logic.

Pushes from one designated low-priority line are dropped without notice once the queue holds more than half its depth. This keeps a chatty pointing device from crowding out keyboard and console traffic. A push into a queue that already holds depth minus one entries is an overrun. The oldest entry is discarded, the queue stays at depth minus one, and a sticky overrun flag is raised.

Each host read produces a one-cycle clear pulse for the receive-done status and the interrupt. The pulse comes whether or not the queue had data.

Top module: `rx_tag_queue`

## Requirements
- R1: After reset the queue is empty, `data_avail` and `overrun` are 0, `rd_word` is 0x0000 and `rdone_clr` is 0.
- R2: Entries come out in push order. In the word registered on the edge that takes a pop of a non-empty queue, bit 15 is 1, bits [9:8] hold the line number, bits [7:0] hold the character, and all other bits are 0.
- R3: A pop of an empty queue returns 0x0000 (valid bit clear, line 0, character 0) and removes nothing. Later pops still return the stored entries in order.
- R4: `data_avail` is 1 exactly when the queue holds at least one entry after the most recent clock edge.
- R5: A push whose line equals `LOWPRI_LINE` is discarded when occupancy before the edge is greater than DEPTH/2. At exactly DEPTH/2 it is accepted. Pushes from other lines are never discarded for congestion.
- R6: An accepted push into a queue holding DEPTH-1 entries, with no pop on the same edge, sets `overrun`. The oldest entry is lost and occupancy stays DEPTH-1. `overrun` stays 1 until reset.
- R7: A pop of a non-empty queue and an accepted push on the same edge both take effect, and occupancy is unchanged. This is not an overrun, even at DEPTH-1.
- R8: Every pop request, on an empty or non-empty queue, makes `rdone_clr` 1 for exactly the cycle after the edge that takes it. Otherwise `rdone_clr` is 0.
- R9: The read and write positions wrap to the first slot after the last one, and ordering is kept across any number of wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Offer a received character this cycle |
| push_char | input | 8 | Received character |
| push_line | input | 2 | Number of the line that received it |
| pop_req | input | 1 | Host read of the receive word this cycle |
| rd_word | output | 16 | Registered receive word: bit 15 valid, [9:8] line, [7:0] character |
| rdone_clr | output | 1 | One-cycle pulse after each host read, clearing receive-done and the interrupt |
| data_avail | output | 1 | Queue holds at least one entry |
| overrun | output | 1 | Sticky overrun indication |

## Verification
A push and a host pop can land on the same edge. The hard cases are a push into an empty queue while it is being popped, and a push at depth minus one while a pop frees a slot. The bench provokes both: directed sequences fill the queue to those levels, and seeded random traffic keeps occupancy drifting over the whole range with both strobes often high together. A bench model decides for each edge whether the pop hit, whether the push was dropped or overran, and what word comes back. Occupancy is judged through later pop results, `data_avail` and `overrun`.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int CHAR_W    = 8;
    localparam int LINE_W    = 2;
    localparam int WORD_W    = 16;
    localparam int VALID_POS = 15;
    localparam int LINE_LSB  = 8;

    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic [CHAR_W-1:0] ch;
    } rxq_entry_t;

    localparam int ENTRY_W = $bits(rxq_entry_t);

    function automatic logic [WORD_W-1:0] pack_word(input logic hit, input rxq_entry_t e);
        logic [WORD_W-1:0] w;
        w = '0;
        if (hit) begin
            w[VALID_POS]                    = 1'b1;
            w[LINE_LSB +: LINE_W]           = e.line;
            w[CHAR_W-1:0]                   = e.ch;
        end
        return w;
    endfunction
endpackage

// File: rtl/rxq_ptr_ctrl.sv
module rxq_ptr_ctrl #(
    parameter int DEPTH       = 64,
    parameter int LOWPRI_LINE = 3,
    localparam int AW         = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_valid,
    input  logic [1:0]    push_line,
    input  logic          pop_req,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic          pop_hit,
    output logic          data_avail,
    output logic          overrun
);
    localparam logic [AW-1:0] HALF_C = AW'(DEPTH / 2);
    localparam logic [AW-1:0] ONE_C  = AW'(1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic          ovr;
    } ctrl_st_t;

    ctrl_st_t st_q, st_d;
    logic [AW-1:0] occ;
    logic          empty, drop, push_acc, wrap_loss;

    always_comb begin
        st_d      = st_q;
        occ       = st_q.wp - st_q.rp;
        empty     = (occ == '0);
        pop_hit   = pop_req && !empty;
        drop      = (push_line == 2'(LOWPRI_LINE)) && (occ > HALF_C);
        push_acc  = push_valid && !drop;
        wrap_loss = push_acc && !pop_hit && (occ == '1);
        if (push_acc)
            st_d.wp = st_q.wp + ONE_C;
        if (pop_hit || wrap_loss)
            st_d.rp = st_q.rp + ONE_C;
        if (wrap_loss)
            st_d.ovr = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign wr_en      = push_acc;
    assign wr_addr    = st_q.wp;
    assign rd_addr    = st_q.rp;
    assign data_avail = !empty;
    assign overrun    = st_q.ovr;

    AST_PUSH_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (push_acc && !pop_hit) |=> data_avail); // R4
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun); // R6
    AST_LOWPRI_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && push_line == 2'(LOWPRI_LINE) && occ > HALF_C) |=> $stable(wr_addr)); // R5
    AST_EMPTY_POP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !data_avail) |=> $stable(rd_addr)); // R3
    AST_SAME_EDGE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_hit && push_acc) |=> ((wr_addr - rd_addr) == $past(occ))); // R7
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  rxq_pkg::rxq_entry_t  wr_entry,
    input  logic [AW-1:0]        rd_addr,
    output rxq_pkg::rxq_entry_t  rd_entry
);
    rxq_pkg::rxq_entry_t slots_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en)
            slots_q[wr_addr] <= wr_entry;
    end

    assign rd_entry = slots_q[rd_addr];
endmodule

// File: rtl/rxq_word_pack.sv
module rxq_word_pack (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          pop_req,
    input  logic                          pop_hit,
    input  rxq_pkg::rxq_entry_t           head,
    output logic [rxq_pkg::WORD_W-1:0]    rd_word,
    output logic                          rdone_clr
);
    typedef struct packed {
        logic [rxq_pkg::WORD_W-1:0] word;
        logic                       clr;
    } pack_st_t;

    pack_st_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        st_d.clr = pop_req;
        if (pop_req)
            st_d.word = rxq_pkg::pack_word(pop_hit, head);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign rd_word   = st_q.word;
    assign rdone_clr = st_q.clr;

    AST_CLR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req |=> rdone_clr); // R8
    AST_NO_STRAY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_req |=> !rdone_clr); // R8
endmodule

// File: rtl/rx_tag_queue.sv
module rx_tag_queue #(
    parameter int DEPTH       = 64,
    parameter int LOWPRI_LINE = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push_valid,
    input  logic [7:0]  push_char,
    input  logic [1:0]  push_line,
    input  logic        pop_req,
    output logic [15:0] rd_word,
    output logic        rdone_clr,
    output logic        data_avail,
    output logic        overrun
);
    localparam int AW = $clog2(DEPTH);

    logic                wr_en, pop_hit;
    logic [AW-1:0]       wr_addr, rd_addr;
    rxq_pkg::rxq_entry_t wr_entry, head;

    assign wr_entry.line = push_line;
    assign wr_entry.ch   = push_char;

    rxq_ptr_ctrl #(.DEPTH(DEPTH), .LOWPRI_LINE(LOWPRI_LINE)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (push_valid),
        .push_line  (push_line),
        .pop_req    (pop_req),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .rd_addr    (rd_addr),
        .pop_hit    (pop_hit),
        .data_avail (data_avail),
        .overrun    (overrun)
    );

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_entry (wr_entry),
        .rd_addr  (rd_addr),
        .rd_entry (head)
    );

    rxq_word_pack u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .pop_req   (pop_req),
        .pop_hit   (pop_hit),
        .head      (head),
        .rd_word   (rd_word),
        .rdone_clr (rdone_clr)
    );

    AST_INVALID_WORD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_word[15] |-> (rd_word == 16'h0000)); // R3
    AST_VALID_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !data_avail) |=> !rd_word[15]); // R2
endmodule

// File: tb/rx_tag_queue_tb.sv
module rx_tag_queue_tb;
    localparam int DEPTH = 64;
    localparam int LOWP  = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_valid = 1'b0;
    logic [7:0]  push_char = '0;
    logic [1:0]  push_line = '0;
    logic        pop_req = 1'b0;
    logic [15:0] rd_word;
    logic        rdone_clr, data_avail, overrun;

    int checks = 0;
    int errors = 0;
    logic [9:0] mq[$];
    bit exp_ovr = 1'b0;

    always #5 clk = ~clk;

    rx_tag_queue #(.DEPTH(DEPTH), .LOWPRI_LINE(LOWP)) u_dut (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_char(push_char),
        .push_line(push_line), .pop_req(pop_req), .rd_word(rd_word),
        .rdone_clr(rdone_clr), .data_avail(data_avail), .overrun(overrun)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] exp_word(input bit hit, input logic [9:0] e);
        return hit ? {1'b1, 5'b0, e} : 16'h0000;
    endfunction

    // One edge of stimulus; expected results from the requirement rules.
    task automatic step(input bit pu, input logic [7:0] ch, input logic [1:0] ln, input bit po);
        int pre;
        bit hit;
        logic [15:0] w;
        pre = mq.size();
        hit = po && (pre > 0);
        w = exp_word(hit, hit ? mq[0] : 10'h0);
        push_valid = pu; push_char = ch; push_line = ln; pop_req = po;
        if (hit) void'(mq.pop_front());
        if (pu && !(ln == 2'(LOWP) && pre > DEPTH/2)) begin   // R5 drop rule
            mq.push_back({ln, ch});
            if (mq.size() == DEPTH) begin                       // R6 oldest lost
                void'(mq.pop_front());
                exp_ovr = 1'b1;
            end
        end
        @(posedge clk); #1;
        if (po) check(hit ? "R2 word" : "R3 empty word", rd_word, w);
        check("R8 clear pulse", rdone_clr, po);
        check("R4 data_avail", data_avail, mq.size() > 0);
        check("R6 overrun", overrun, exp_ovr);
        @(negedge clk);
        push_valid = 0; pop_req = 0;
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0007));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 rd_word", rd_word, 16'h0);
        check("R1 data_avail", data_avail, 0);
        check("R1 overrun", overrun, 0);
        check("R1 rdone_clr", rdone_clr, 0);
        @(negedge clk);

        // R3: empty pop, then a push and a pop of the same edge on empty (R7)
        step(0, 8'h00, 2'd0, 1);
        step(1, 8'hA5, 2'd2, 1);
        step(0, 8'h00, 2'd0, 1);
        // R5: fill to exactly DEPTH/2, low-pri accepted, then dropped
        for (int i = 0; i < DEPTH/2; i++) step(1, 8'(i), 2'd0, 0);
        step(1, 8'hC3, 2'(LOWP), 0);
        step(1, 8'hC4, 2'(LOWP), 0);
        step(1, 8'h77, 2'd1, 0);
        // R6: fill to DEPTH-1, same-edge push+pop at the limit (R7), then overrun
        while (mq.size() < DEPTH-1) step(1, 8'($urandom), 2'd1, 0);
        step(1, 8'h5A, 2'd2, 1);
        step(1, 8'h11, 2'd0, 0);
        step(1, 8'h12, 2'd2, 0);
        // drain fully and check order (R2, R9), then one empty pop
        while (mq.size() > 0) step(0, 8'h00, 2'd0, 1);
        step(0, 8'h00, 2'd0, 1);

        // R9 + random mix: many wraps
        for (int n = 0; n < 4000; n++) begin
            bit pu, po;
            pu = ($urandom % 100) < 55;
            po = ($urandom % 100) < 50;
            step(pu, 8'($urandom), 2'($urandom), po);
        end
        while (mq.size() > 0) step(0, 8'h00, 2'd0, 1);
        step(0, 8'h00, 2'd0, 1);   // R9 wrap order kept, queue empty again

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule